// File: doc/BRIEF.md
# Execute-Stage Stall and Redirect Controller

This block is the control logic of the combined decode/execute stage in a two-stage in-order RISC-V pipeline. In every cycle it decides whether the instruction held in that stage completes or stays for another cycle. It also decides when the fetch stage must be flushed and a new program counter requested from instruction memory. Its inputs are the decoded class of the instruction, the branch-condition result from the shared ALU, the data-memory response handshake, and the instruction-memory grant and data-valid signals. The ALU, the register file and the prefetch buffer sit outside the block.

Instructions that need only the ALU finish in their first cycle, so with no stalls one instruction leaves the stage per cycle. If an instruction stalls for X cycles, the next one enters the stage X+1 cycles later. Loads and stores wait in the stage for the data-memory response. Jumps and instruction fences issue their new PC in their first cycle. A taken branch uses the single ALU twice: first for the condition, then for the target, and it issues the new PC in that second cycle. Every redirect then waits until the first instruction at the new address comes back.

Top module: `exs_stall_ctrl`

## Requirements
- R1: The class code on `id_class_i` is 0 = ALU, 1 = CSR, 2 = load, 3 = store, 4 = jump, 5 = conditional branch, 6 = instruction fence, 7 = treated as ALU. A valid ALU, CSR or not-taken branch (class 5 with `br_taken_i` low) in an idle stage completes in the same cycle: `stall_o`, `pc_set_o` and `fetch_flush_o` stay low.
- R2: A valid load or store raises `stall_o` in its first cycle and in every following cycle that has no `dmem_rvalid_i`. `stall_o` drops in the cycle the response arrives. A response seen in the first cycle is ignored.
- R3: `rf_load_we_o` is high exactly in the response cycle of a load whose response has `dmem_err_i` low. A store never raises it.
- R4: A response with `dmem_err_i` high still ends the stall. It raises `lsu_exc_o` for that one cycle only and holds `rf_load_we_o` low.
- R5: A valid jump or instruction fence in an idle stage raises `pc_set_o`, `fetch_flush_o` and `stall_o` in its first cycle.
- R6: For a taken branch, the first cycle has `stall_o` high, `alu_phase_o` low (condition) and no redirect. The second cycle has `stall_o` and `alu_phase_o` high (target), and `pc_set_o` and `fetch_flush_o` high.
- R7: After a redirect, `stall_o` stays high until `imem_rvalid_i` arrives after the request was granted. While `imem_gnt_i` is low, `pc_set_o` is driven again each cycle. `fetch_flush_o` lasts one cycle only.
- R8: With `id_valid_i` low in an idle stage, there is no stall, no redirect and no register write.
- R9: Reset puts the controller in its idle state with all outputs low, and it discards any access that was still open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid_i | input | 1 | An instruction is present in decode/execute |
| id_class_i | input | 3 | Decoded instruction class |
| br_taken_i | input | 1 | Branch condition from the ALU |
| dmem_rvalid_i | input | 1 | Data-memory response valid |
| dmem_err_i | input | 1 | Data-memory response error |
| imem_gnt_i | input | 1 | Instruction memory accepted the PC request |
| imem_rvalid_i | input | 1 | Instruction data returned from the new PC |
| stall_o | output | 1 | Hold the instruction in decode/execute |
| alu_phase_o | output | 1 | ALU operand phase: 0 condition, 1 target |
| fetch_flush_o | output | 1 | Flush the fetch stage and prefetch buffer |
| pc_set_o | output | 1 | Drive the new PC to instruction memory |
| rf_load_we_o | output | 1 | Register-file write enable for load data |
| lsu_exc_o | output | 1 | Data-memory error exception, one cycle |

## Verification
The block has no parameters that change its behaviour. The bench therefore builds it with the single class width fixed in the package and relies on input patterns to reach every state path. These patterns cover a response in the acceptance cycle, a grant held back over several cycles while data-valid is already high, and an error response after a load. They also cover a reset that arrives while a load is still waiting.

// File: rtl/exs_ctrl_pkg.sv
package exs_ctrl_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 3'd0,
    CLS_CSR    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_JUMP   = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_FENCEI = 3'd6,
    CLS_RSVD   = 3'd7
  } instr_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_BR_TARGET  = 2'd1,
    ST_WAIT_FETCH = 2'd2,
    ST_WAIT_LSU   = 2'd3
  } exs_state_e;

  typedef struct packed {
    logic mem;
    logic load;
    logic redirect;
    logic branch;
  } cls_flags_t;
endpackage

// File: rtl/exs_class_decode.sv
module exs_class_decode
  import exs_ctrl_pkg::*;
(
  input  logic             valid_i,
  input  logic [CLS_W-1:0] cls_i,
  output cls_flags_t       flags_o
);
  instr_cls_e cls;

  always_comb begin
    cls            = instr_cls_e'(cls_i);
    flags_o        = '0;
    if (valid_i) begin
      flags_o.mem      = (cls == CLS_LOAD) || (cls == CLS_STORE);
      flags_o.load     = (cls == CLS_LOAD);
      flags_o.redirect = (cls == CLS_JUMP) || (cls == CLS_FENCEI);
      flags_o.branch   = (cls == CLS_BRANCH);
    end
  end
endmodule

// File: rtl/exs_fetch_tracker.sv
module exs_fetch_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic gnt_i,
  output logic pc_set_o,
  output logic pend_o
);
  logic pend_q, pend_d, pend_en;

  // request stays pending until the instruction memory grants it
  assign pend_en  = issue_i | gnt_i;
  assign pend_d   = (issue_i | pend_q) & ~gnt_i;
  assign pc_set_o = issue_i | pend_q;
  assign pend_o   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/exs_ctrl_fsm.sv
module exs_ctrl_fsm
  import exs_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cls_flags_t flags_i,
  input  logic       br_taken_i,
  input  logic       dmem_rvalid_i,
  input  logic       dmem_err_i,
  input  logic       fetch_pend_i,
  input  logic       imem_rvalid_i,
  output logic       stall_o,
  output logic       alu_phase_o,
  output logic       issue_o,
  output logic       rf_we_o,
  output logic       exc_o
);
  exs_state_e st_q, st_d;
  logic       is_load_q, is_load_d, load_en;

  always_comb begin
    st_d        = st_q;
    stall_o     = 1'b0;
    alu_phase_o = 1'b0;
    issue_o     = 1'b0;
    rf_we_o     = 1'b0;
    exc_o       = 1'b0;
    load_en     = 1'b0;
    is_load_d   = is_load_q;
    unique case (st_q)
      ST_IDLE: begin
        if (flags_i.mem) begin
          stall_o   = 1'b1;
          load_en   = 1'b1;
          is_load_d = flags_i.load;
          st_d      = ST_WAIT_LSU;
        end else if (flags_i.redirect) begin
          stall_o = 1'b1;
          issue_o = 1'b1;
          st_d    = ST_WAIT_FETCH;
        end else if (flags_i.branch && br_taken_i) begin
          stall_o = 1'b1;
          st_d    = ST_BR_TARGET;
        end
      end
      ST_BR_TARGET: begin
        stall_o     = 1'b1;
        alu_phase_o = 1'b1;
        issue_o     = 1'b1;
        st_d        = ST_WAIT_FETCH;
      end
      ST_WAIT_FETCH: begin
        if (!fetch_pend_i && imem_rvalid_i) st_d = ST_IDLE;
        else                                stall_o = 1'b1;
      end
      ST_WAIT_LSU: begin
        if (dmem_rvalid_i) begin
          st_d    = ST_IDLE;
          rf_we_o = is_load_q & ~dmem_err_i;
          exc_o   = dmem_err_i;
        end else begin
          stall_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              st_q <= ST_IDLE;
    else if (st_d != st_q)   st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       is_load_q <= 1'b0;
    else if (load_en) is_load_q <= is_load_d;
  end
endmodule

// File: rtl/exs_stall_ctrl.sv
module exs_stall_ctrl
  import exs_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid_i,
  input  logic [CLS_W-1:0] id_class_i,
  input  logic             br_taken_i,
  input  logic             dmem_rvalid_i,
  input  logic             dmem_err_i,
  input  logic             imem_gnt_i,
  input  logic             imem_rvalid_i,
  output logic             stall_o,
  output logic             alu_phase_o,
  output logic             fetch_flush_o,
  output logic             pc_set_o,
  output logic             rf_load_we_o,
  output logic             lsu_exc_o
);
  cls_flags_t flags;
  logic       issue, pend;

  exs_class_decode u_dec (
    .valid_i (id_valid_i),
    .cls_i   (id_class_i),
    .flags_o (flags)
  );

  exs_ctrl_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .flags_i       (flags),
    .br_taken_i    (br_taken_i),
    .dmem_rvalid_i (dmem_rvalid_i),
    .dmem_err_i    (dmem_err_i),
    .fetch_pend_i  (pend),
    .imem_rvalid_i (imem_rvalid_i),
    .stall_o       (stall_o),
    .alu_phase_o   (alu_phase_o),
    .issue_o       (issue),
    .rf_we_o       (rf_load_we_o),
    .exc_o         (lsu_exc_o)
  );

  exs_fetch_tracker u_ftr (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue),
    .gnt_i    (imem_gnt_i),
    .pc_set_o (pc_set_o),
    .pend_o   (pend)
  );

  // flush only on the first redirect cycle
  assign fetch_flush_o = issue;
endmodule

// File: rtl/exs_ctrl_checker.sv
module exs_ctrl_checker
  import exs_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid_i,
  input logic [CLS_W-1:0] id_class_i,
  input logic             dmem_rvalid_i,
  input logic             dmem_err_i,
  input logic             stall_o,
  input logic             alu_phase_o,
  input logic             fetch_flush_o,
  input logic             pc_set_o,
  input logic             rf_load_we_o,
  input logic             lsu_exc_o
);
  assert_simple_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stall_o) && id_valid_i &&
     (id_class_i == CLS_ALU || id_class_i == CLS_CSR)) |-> !stall_o);

  assert_write_needs_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_load_we_o |-> (dmem_rvalid_i && !dmem_err_i && !stall_o));

  assert_exc_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_exc_o |=> !lsu_exc_o);

  assert_exc_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_exc_o |-> (!rf_load_we_o && !stall_o));

  assert_flush_with_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_flush_o |-> (pc_set_o && stall_o));

  assert_target_after_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alu_phase_o |-> ($past(stall_o) && !$past(alu_phase_o)));

  assert_flush_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_flush_o |=> !fetch_flush_o);

  assert_bubble_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stall_o) && !id_valid_i) |-> (!stall_o && !pc_set_o && !rf_load_we_o));
endmodule

bind exs_stall_ctrl exs_ctrl_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .id_valid_i    (id_valid_i),
  .id_class_i    (id_class_i),
  .dmem_rvalid_i (dmem_rvalid_i),
  .dmem_err_i    (dmem_err_i),
  .stall_o       (stall_o),
  .alu_phase_o   (alu_phase_o),
  .fetch_flush_o (fetch_flush_o),
  .pc_set_o      (pc_set_o),
  .rf_load_we_o  (rf_load_we_o),
  .lsu_exc_o     (lsu_exc_o)
);

// File: tb/exs_stall_ctrl_tb.sv
module exs_stall_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       id_valid_i;
  logic [2:0] id_class_i;
  logic       br_taken_i, dmem_rvalid_i, dmem_err_i, imem_gnt_i, imem_rvalid_i;
  logic       stall_o, alu_phase_o, fetch_flush_o, pc_set_o, rf_load_we_o, lsu_exc_o;

  int n_tests = 0;
  int n_fail  = 0;

  exs_stall_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid_i), .id_class_i(id_class_i),
    .br_taken_i(br_taken_i), .dmem_rvalid_i(dmem_rvalid_i), .dmem_err_i(dmem_err_i),
    .imem_gnt_i(imem_gnt_i), .imem_rvalid_i(imem_rvalid_i),
    .stall_o(stall_o), .alu_phase_o(alu_phase_o), .fetch_flush_o(fetch_flush_o),
    .pc_set_o(pc_set_o), .rf_load_we_o(rf_load_we_o), .lsu_exc_o(lsu_exc_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {valid, class[2:0], taken, drv, derr, gnt, irv} then
  //         expected {stall, phase, flush, pcset, we, exc}
  localparam int NV = 23;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,3'd0,5'b00000, 6'b000000}, // R1 ALU
    {1'b1,3'd1,5'b00000, 6'b000000}, // R1 CSR
    {1'b1,3'd5,5'b00000, 6'b000000}, // R1 branch not taken
    {1'b1,3'd2,5'b00000, 6'b100000}, // R2 load accepted
    {1'b1,3'd2,5'b00000, 6'b100000}, // R2 waiting
    {1'b1,3'd2,5'b01000, 6'b000010}, // R3 load data write
    {1'b1,3'd3,5'b00000, 6'b100000}, // R2 store accepted
    {1'b1,3'd3,5'b01000, 6'b000000}, // R3 store: no write
    {1'b1,3'd2,5'b00000, 6'b100000}, // R2 load accepted
    {1'b1,3'd2,5'b01100, 6'b000001}, // R4 error response
    {1'b1,3'd4,5'b00010, 6'b101100}, // R5 jump, granted
    {1'b1,3'd4,5'b00000, 6'b100000}, // R7 waiting for data
    {1'b1,3'd4,5'b00001, 6'b000000}, // R7 data returns
    {1'b1,3'd5,5'b10000, 6'b100000}, // R6 condition phase
    {1'b1,3'd5,5'b10010, 6'b111100}, // R6 target phase
    {1'b1,3'd5,5'b00001, 6'b000000}, // R7 data returns
    {1'b1,3'd6,5'b00000, 6'b101100}, // R5 fence, not granted
    {1'b1,3'd6,5'b00001, 6'b100100}, // R7 re-request, early data ignored
    {1'b1,3'd6,5'b00010, 6'b100100}, // R7 granted now
    {1'b1,3'd6,5'b00001, 6'b000000}, // R7 data returns
    {1'b0,3'd2,5'b01000, 6'b000000}, // R8 bubble
    {1'b1,3'd2,5'b01000, 6'b100000}, // R2 response in first cycle ignored
    {1'b1,3'd2,5'b01000, 6'b000010}  // R3 write on real response
  };
  localparam int VREQ [NV] = '{1,1,1,2,2,3,2,3,2,4,5,7,7,6,6,7,5,7,7,7,8,2,3};

  task automatic drive(input logic [8:0] s);
    {id_valid_i, id_class_i, br_taken_i, dmem_rvalid_i, dmem_err_i,
     imem_gnt_i, imem_rvalid_i} = s;
  endtask

  task automatic check(input int req, input logic [5:0] exp);
    logic [5:0] act;
    act = {stall_o, alu_phase_o, fetch_flush_o, pc_set_o, rf_load_we_o, lsu_exc_o};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: outputs {stall,phase,flush,pcset,we,exc} actual %b expected %b",
               req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(9'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(9, 6'b000000); // R9 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(9, 6'b000000); // R9 idle after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:6]);
      #2;
      check(VREQ[i], VEC[i][5:0]);
      @(negedge clk);
    end

    // R9: reset while a load waits, the stale response must not write
    drive({1'b1, 3'd2, 5'b00000});
    #2;
    check(2, 6'b100000);
    @(negedge clk);
    drive(9'b0);
    rst_n = 1'b0;
    #2;
    check(9, 6'b000000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive({1'b1, 3'd0, 5'b01000});
    #2;
    check(9, 6'b000000); // R9 open load discarded
    @(negedge clk);

    // R1: reserved class code 7 behaves as ALU
    drive({1'b1, 3'd7, 5'b00000});
    #2;
    check(1, 6'b000000);
    @(negedge clk);

    // R7: long fetch wait holds the stall
    drive({1'b1, 3'd4, 5'b00010});
    #2;
    check(5, 6'b101100);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      drive({1'b1, 3'd4, 5'b00000});
      #2;
      check(7, 6'b100000);
      @(negedge clk);
    end
    drive({1'b1, 3'd4, 5'b00001});
    #2;
    check(7, 6'b000000);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule